// File: doc/BRIEF.md
# Sticky Status and Command Flag Controller

This block keeps the operating flags of a serial controller: an enable flag (0 selects configuration mode, where speed and word width may be changed; 1 selects active mode), a master-select flag, and six sticky error flags. Software never writes the flags directly. It writes a separate command word in which every flag has its own clear bit and its own set bit, so that a write touches only the flags it names.

The shift engine and FIFOs sit outside this block. They report errors as single-cycle pulses. Each pulse except mode error is gated by its own enable input. A readable status word shows the flags, a busy bit and a 3-bit received-byte-valid count. A combined error interrupt is asserted while any error flag is set.

Top module: `sticky_status_ctrl`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `status_word` is all zero and `err_irq` is 0.
- R2: A command write (`cmd_we`=1) sets flags through these bits: 1 enable, 3 master, 5 receive underflow, 7 mode error, 12 transmit overflow, 13 receive overflow, 14 abort, 15 transmit underflow. The result is visible in `status_word` after the next clock edge.
- R3: A command write clears flags through these bits: 0 enable, 2 master, 4 receive underflow, 6 mode error, 8 transmit overflow, 9 receive overflow, 10 abort, 11 transmit underflow.
- R4: When a flag's set bit and clear bit are both 1 in one write, that flag keeps its value.
- R5: Command bits that are 0 leave their flags unchanged. With `cmd_we`=0, the command word has no effect.
- R6: The status word places flags at these bits: 0 enable, 1 master, 7 mode error, 8 transmit overflow, 9 receive overflow, 10 abort, 11 transmit underflow, 12 receive underflow. An error pulse on `err_pulse` sets its flag one edge later, and the flag stays set until software clears it. The pulse order is [0] transmit overflow, [1] receive overflow, [2] abort, [3] transmit underflow, [4] receive underflow.
- R7: An error pulse whose `err_enable` bit (same order as `err_pulse`) is 0 leaves its flag unchanged.
- R8: A `mode_err_pulse` sets the mode error flag whatever the `err_enable` value.
- R9: When a hardware error pulse and a software clear hit the same flag in one cycle, the flag ends up set.
- R10: `err_irq` is 1 exactly while at least one of the six error flags is set. Enable and master do not affect it.
- R11: Status bit 13 shows `busy_in`, and bits 30:28 show `rxbv_in`, both one clock edge late. All other status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_word | input | 16 | Paired clear/set command bits |
| err_enable | input | 5 | Per-source error detection enables |
| err_pulse | input | 5 | Single-cycle error events from the shift engine and FIFOs |
| mode_err_pulse | input | 1 | Single-cycle mode error event |
| busy_in | input | 1 | Busy indication from the shift engine |
| rxbv_in | input | 3 | Received-byte-valid count |
| status_word | output | 32 | Readable status |
| err_irq | output | 1 | Combined error interrupt |

## Verification
The bench targets several corner cases. The first is a write with both bits of a pair set: a decoder that lets one side win would change a flag that has to hold. The next is a masked error pulse: missing gating would latch a fault that software disabled. The third is an error pulse that lands in the same cycle as a clear: a design that gives priority to the clear would lose a real error. The bench also swaps pair positions. Misrouted bits would set or clear the wrong flag, and a bad mapping would make the interrupt disagree with the flags or react to enable or master.

// File: rtl/sts_pkg.sv
package sts_pkg;
  localparam int NFLAG = 8;
  localparam int NGATED = 5;
  localparam int FIRST_ERR = 2;

  // Flag order inside the block:
  // 0 enable, 1 master, 2 mode error, 3 tx overflow,
  // 4 rx overflow, 5 abort, 6 tx underflow, 7 rx underflow
  function automatic int clr_pos(input int i);
    case (i)
      0: return 0;
      1: return 2;
      2: return 6;
      3: return 8;
      4: return 9;
      5: return 10;
      6: return 11;
      default: return 4;
    endcase
  endfunction

  function automatic int set_pos(input int i);
    case (i)
      0: return 1;
      1: return 3;
      2: return 7;
      3: return 12;
      4: return 13;
      5: return 14;
      6: return 15;
      default: return 5;
    endcase
  endfunction

  function automatic int stat_pos(input int i);
    case (i)
      0: return 0;
      1: return 1;
      2: return 7;
      3: return 8;
      4: return 9;
      5: return 10;
      6: return 11;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/sts_cmd_decode.sv
module sts_cmd_decode #(
  parameter int CMD_W = 16,
  parameter int NF = sts_pkg::NFLAG
) (
  input  logic             we_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic [NF-1:0]    set_o,
  output logic [NF-1:0]    clr_o
);
  for (genvar g = 0; g < NF; g++) begin : g_pair
    assign set_o[g] = we_i & cmd_i[sts_pkg::set_pos(g)];
    assign clr_o[g] = we_i & cmd_i[sts_pkg::clr_pos(g)];
  end
endmodule

// File: rtl/sts_flag_cell.sv
module sts_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic hw_i,
  output logic nxt_o,
  output logic q_o
);
  always_comb begin
    nxt_o = q_o;
    if (hw_i)
      nxt_o = 1'b1;
    else if (set_i && !clr_i)
      nxt_o = 1'b1;
    else if (clr_i && !set_i)
      nxt_o = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= nxt_o;
  end

  AST_HW_STICKS: assert property (@(posedge clk) disable iff (rst)
    hw_i |=> q_o); // R6
  AST_PAIR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (set_i && clr_i && !hw_i) |=> $stable(q_o)); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i && !hw_i) |=> $stable(q_o)); // R5
endmodule

// File: rtl/sticky_status_ctrl.sv
module sticky_status_ctrl #(
  parameter int CMD_W    = 16,
  parameter int STAT_W   = 32,
  parameter int RXBV_W   = 3,
  parameter int RXBV_LSB = 28,
  parameter int BUSY_BIT = 13
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cmd_we,
  input  logic [CMD_W-1:0]          cmd_word,
  input  logic [sts_pkg::NGATED-1:0] err_enable,
  input  logic [sts_pkg::NGATED-1:0] err_pulse,
  input  logic                      mode_err_pulse,
  input  logic                      busy_in,
  input  logic [RXBV_W-1:0]         rxbv_in,
  output logic [STAT_W-1:0]         status_word,
  output logic                      err_irq
);
  localparam int NF   = sts_pkg::NFLAG;
  localparam int NG   = sts_pkg::NGATED;
  localparam int FE   = sts_pkg::FIRST_ERR;
  localparam int GOFF = FE + 1;

  logic [NF-1:0] set_v, clr_v, hw_v, nxt_v, q_v;
  logic busy_q;
  logic [RXBV_W-1:0] rxbv_q;

  sts_cmd_decode #(.CMD_W(CMD_W), .NF(NF)) u_dec (
    .we_i(cmd_we), .cmd_i(cmd_word), .set_o(set_v), .clr_o(clr_v)
  );

  assign hw_v[0]  = 1'b0;
  assign hw_v[1]  = 1'b0;
  assign hw_v[FE] = mode_err_pulse;
  for (genvar g = 0; g < NG; g++) begin : g_gate
    assign hw_v[GOFF+g] = err_pulse[g] & err_enable[g];
  end

  for (genvar f = 0; f < NF; f++) begin : g_flag
    sts_flag_cell u_cell (
      .clk(clk), .rst(rst), .set_i(set_v[f]), .clr_i(clr_v[f]),
      .hw_i(hw_v[f]), .nxt_o(nxt_v[f]), .q_o(q_v[f])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      rxbv_q  <= '0;
      err_irq <= 1'b0;
    end else begin
      busy_q  <= busy_in;
      rxbv_q  <= rxbv_in;
      err_irq <= |nxt_v[NF-1:FE];
    end
  end

  always_comb begin
    status_word = '0;
    for (int f = 0; f < NF; f++)
      status_word[sts_pkg::stat_pos(f)] = q_v[f];
    status_word[BUSY_BIT] = busy_q;
    status_word[RXBV_LSB +: RXBV_W] = rxbv_q;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (status_word == '0 && !err_irq)); // R1
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    err_irq == (|q_v[NF-1:FE])); // R10
  AST_CLEAR_EN: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd_word[0] && !cmd_word[1]) |=> !status_word[0]); // R3
  AST_MASKED_ABORT: assert property (@(posedge clk) disable iff (rst)
    (!err_enable[2] && err_pulse[2] && !status_word[10] &&
     !(cmd_we && cmd_word[14])) |=> !status_word[10]); // R7
  AST_BUSY_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> status_word[BUSY_BIT] == $past(busy_in)); // R11
endmodule

// File: tb/test_sticky_status_ctrl.sv
module test_sticky_status_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_we = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [4:0] err_enable = '0;
  logic [4:0] err_pulse = '0;
  logic mode_err_pulse = 1'b0;
  logic busy_in = 1'b0;
  logic [2:0] rxbv_in = '0;
  logic [31:0] status_word;
  logic err_irq;

  int errors = 0;
  int checks = 0;
  bit [31:0] exp_stat = '0;
  bit exp_irq = 1'b0;

  always #5 clk = ~clk;

  sticky_status_ctrl i_sticky_status_ctrl (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_word(cmd_word),
    .err_enable(err_enable), .err_pulse(err_pulse),
    .mode_err_pulse(mode_err_pulse), .busy_in(busy_in), .rxbv_in(rxbv_in),
    .status_word(status_word), .err_irq(err_irq)
  );

  // Reference model: pair table (clear bit, set bit, status bit)
  int clr_b [8] = '{0, 2, 4, 6, 8, 9, 10, 11};
  int set_b [8] = '{1, 3, 5, 7, 12, 13, 14, 15};
  int st_b  [8] = '{0, 1, 12, 7, 8, 9, 10, 11};

  always @(posedge clk) begin
    bit [7:0] hw;
    hw = '0;
    hw[2] = err_pulse[4] & err_enable[4];
    hw[3] = mode_err_pulse;
    hw[4] = err_pulse[0] & err_enable[0];
    hw[5] = err_pulse[1] & err_enable[1];
    hw[6] = err_pulse[2] & err_enable[2];
    hw[7] = err_pulse[3] & err_enable[3];
    if (rst) begin
      exp_stat = '0;
    end else begin
      for (int i = 0; i < 8; i++) begin
        bit s, c;
        s = cmd_we & cmd_word[set_b[i]];
        c = cmd_we & cmd_word[clr_b[i]];
        if (hw[i]) exp_stat[st_b[i]] = 1'b1;
        else if (s && !c) exp_stat[st_b[i]] = 1'b1;
        else if (c && !s) exp_stat[st_b[i]] = 1'b0;
      end
      exp_stat[13] = busy_in;
      exp_stat[30:28] = rxbv_in;
    end
    exp_irq = |exp_stat[12:7];
  end

  task automatic compare(input string tag);
    checks++;
    if (status_word !== exp_stat) begin
      errors++;
      $display("FAIL %s status actual=%h expected=%h", tag, status_word, exp_stat);
    end
    checks++;
    if (err_irq !== exp_irq) begin
      errors++;
      $display("FAIL %s err_irq actual=%b expected=%b", tag, err_irq, exp_irq);
    end
  endtask

  task automatic step(input string tag, input bit we, input bit [15:0] cmd,
                      input bit [4:0] en, input bit [4:0] ev, input bit evm,
                      input bit bsy, input bit [2:0] bv);
    cmd_we = we; cmd_word = cmd; err_enable = en; err_pulse = ev;
    mode_err_pulse = evm; busy_in = bsy; rxbv_in = bv;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    step("R1", 1, 16'hFFFF, 5'h1F, 5'h1F, 1, 1, 3'd7);
    step("R1", 1, 16'hAAAA, 5'h1F, 5'h1F, 1, 1, 3'd7);
    rst = 1'b0;
    step("R1", 0, 16'h0000, 5'h00, 5'h00, 0, 0, 3'd0);
    step("R2", 1, 16'h0002, 5'h00, 5'h00, 0, 0, 3'd0);
    step("R2", 1, 16'h0008, 5'h00, 5'h00, 0, 0, 3'd0);
    step("R2", 1, 16'hF0A0, 5'h00, 5'h00, 0, 0, 3'd0);
    step("R10", 0, 16'h0000, 5'h00, 5'h00, 0, 0, 3'd0);
    step("R3", 1, 16'h0001, 5'h00, 5'h00, 0, 0, 3'd0);
    step("R3", 1, 16'h0F50, 5'h00, 5'h00, 0, 0, 3'd0);
    step("R10", 1, 16'h0002, 5'h00, 5'h00, 0, 0, 3'd0);
    step("R4", 1, 16'h0003, 5'h00, 5'h00, 0, 0, 3'd0);
    step("R4", 1, 16'h0004, 5'h00, 5'h00, 0, 0, 3'd0);
    step("R4", 1, 16'h000C, 5'h00, 5'h00, 0, 0, 3'd0);
    step("R5", 0, 16'hFFFF, 5'h00, 5'h00, 0, 0, 3'd0);
    step("R5", 1, 16'h0000, 5'h00, 5'h00, 0, 0, 3'd0);
    step("R6", 0, 16'h0000, 5'h1F, 5'h04, 0, 0, 3'd0);
    step("R6", 0, 16'h0000, 5'h1F, 5'h00, 0, 0, 3'd0);
    step("R6", 0, 16'h0000, 5'h1F, 5'h1B, 0, 0, 3'd0);
    step("R3", 1, 16'h0F50, 5'h00, 5'h00, 0, 0, 3'd0);
    step("R7", 0, 16'h0000, 5'h00, 5'h1F, 0, 0, 3'd0);
    step("R7", 0, 16'h0000, 5'h1B, 5'h04, 0, 0, 3'd0);
    step("R8", 0, 16'h0000, 5'h00, 5'h00, 1, 0, 3'd0);
    step("R9", 1, 16'h0010, 5'h10, 5'h10, 0, 0, 3'd0);
    step("R9", 1, 16'h0040, 5'h00, 5'h00, 1, 0, 3'd0);
    step("R11", 1, 16'h0F50, 5'h00, 5'h00, 0, 1, 3'd5);
    step("R11", 0, 16'h0000, 5'h00, 5'h00, 0, 0, 3'd2);
    for (int k = 0; k < 400; k++) begin
      bit [15:0] c;
      c = 16'($urandom);
      if (k % 3 == 0) c = c & 16'h00FF;
      step("R4 R5 R6 R7 R10", ($urandom % 4) != 0, c, 5'($urandom),
           5'($urandom) & 5'($urandom), ($urandom % 8) == 0,
           1'($urandom), 3'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule